// File: doc/BRIEF.md
# Two-Input Steered Four-State Sequencer

This block is a small synchronous controller with four states. On each rising clock edge it moves to a state chosen by a 2-bit steering input and its present state. The transition rule is a fixed, irregular table and not a count. A single flag output depends only on the present state, so it is a Moore output. The flag is high in two states that are not neighbours in the encoding.

The state lives in a two-bit register. The next-state rule and the output decode are separate pieces of combinational logic around that register. A synchronous, active-high reset returns the machine to its home state. Reset wins over any steering value applied in the same cycle.

Top module: `quad_steer_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine enters the home state A (encoding 2'b00) whatever `steer` is. After that edge `mark` reads 1.
- R2: From A, `steer` values 2'b00, 2'b01, 2'b10 and 2'b11 lead to A, B, C and D respectively. The encodings are A=00, B=01, C=10 and D=11.
- R3: From B, `steer` values 2'b00, 2'b01, 2'b10 and 2'b11 lead to A, D, B and D respectively.
- R4: From C, `steer` values 2'b00, 2'b01, 2'b10 and 2'b11 lead to B, D, C and A respectively.
- R5: From D, `steer` values 2'b00, 2'b01, 2'b10 and 2'b11 lead to B, A, A and D respectively.
- R6: `mark` is 1 in states A and C and 0 in states B and D. It is a function of the present state only, so a change of `steer` between clock edges leaves `mark` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state A |
| steer | input | 2 | Steering code that selects the next state |
| mark | output | 1 | Moore flag, high in states A and C |

## Verification
Reset and a state transition can fall in the same cycle. To provoke this, the bench holds `rst` high while `steer` carries a code that would move the machine out of its current state. It then checks that the machine lands in A and not at the table's target. The state is not visible at the ports, so it is identified from `mark` before and after one extra step with `steer`=00. That code sends each of the four states to a successor with a different flag pattern, so each state gives a distinct pair of flag values. The bench uses this to judge all sixteen state/input pairs against its own copy of the table.

// File: rtl/qsf_pkg.sv
package qsf_pkg;

    localparam int STEER_W = 2;
    localparam int STATE_W = 2;
    localparam int N_STATES = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } qsf_state_e;

    typedef logic [STEER_W-1:0] qsf_steer_t;

    // Fixed steering table: present state x steering code -> next state
    function automatic qsf_state_e qsf_next(input qsf_state_e cur, input qsf_steer_t sel);
        qsf_state_e nxt;
        nxt = ST_A;
        unique case (cur)
            ST_A: begin
                unique case (sel)
                    2'b00: nxt = ST_A;
                    2'b01: nxt = ST_B;
                    2'b10: nxt = ST_C;
                    default: nxt = ST_D;
                endcase
            end
            ST_B: begin
                unique case (sel)
                    2'b00: nxt = ST_A;
                    2'b01: nxt = ST_D;
                    2'b10: nxt = ST_B;
                    default: nxt = ST_D;
                endcase
            end
            ST_C: begin
                unique case (sel)
                    2'b00: nxt = ST_B;
                    2'b01: nxt = ST_D;
                    2'b10: nxt = ST_C;
                    default: nxt = ST_A;
                endcase
            end
            default: begin
                unique case (sel)
                    2'b00: nxt = ST_B;
                    2'b01: nxt = ST_A;
                    2'b10: nxt = ST_A;
                    default: nxt = ST_D;
                endcase
            end
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/qsf_next_logic.sv
module qsf_next_logic
    import qsf_pkg::*;
(
    input  qsf_state_e cur,
    input  qsf_steer_t sel,
    output qsf_state_e nxt
);
    always_comb begin
        nxt = qsf_next(cur, sel);
    end
endmodule

// File: rtl/qsf_state_reg.sv
module qsf_state_reg
    import qsf_pkg::*;
#(
    parameter qsf_state_e HOME = ST_A
) (
    input  logic       clk,
    input  logic       rst,
    input  qsf_state_e d,
    output qsf_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= HOME;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/qsf_out_decode.sv
module qsf_out_decode
    import qsf_pkg::*;
(
    input  qsf_state_e cur,
    output logic       flag
);
    // With A=00, B=01, C=10, D=11 the flag is the inverse of the low state bit
    always_comb begin
        flag = ~cur[0];
    end
endmodule

// File: rtl/quad_steer_fsm.sv
module quad_steer_fsm
    import qsf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STEER_W-1:0] steer,
    output logic               mark
);
    qsf_state_e cur_q;
    qsf_state_e nxt_d;

    qsf_next_logic u_next (
        .cur (cur_q),
        .sel (steer),
        .nxt (nxt_d)
    );

    qsf_state_reg #(
        .HOME (ST_A)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_d),
        .q   (cur_q)
    );

    qsf_out_decode u_out (
        .cur  (cur_q),
        .flag (mark)
    );
endmodule

// File: rtl/quad_steer_chk.sv
module quad_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] steer,
    input logic       mark,
    input logic [1:0] cur
);
    // R1
    a_r1_reset_home: assert property (@(posedge clk) rst |=> (cur == 2'b00 && mark));

    // R2
    a_r2_from_a: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b00) |=> (cur == $past(steer)));

    // R3
    a_r3_from_b_hold: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b01 && steer == 2'b10) |=> (cur == 2'b01));
    a_r3_from_b_odd: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b01 && steer[0]) |=> (cur == 2'b11));
    a_r3_from_b_zero: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b01 && steer == 2'b00) |=> (cur == 2'b00));

    // R4
    a_r4_from_c_zero: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b10 && steer == 2'b00) |=> (cur == 2'b01));
    a_r4_from_c_one: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b10 && steer == 2'b01) |=> (cur == 2'b11));
    a_r4_from_c_two: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b10 && steer == 2'b10) |=> (cur == 2'b10));
    a_r4_from_c_three: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b10 && steer == 2'b11) |=> (cur == 2'b00));

    // R5
    a_r5_from_d_zero: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b11 && steer == 2'b00) |=> (cur == 2'b01));
    a_r5_from_d_mixed: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b11 && (steer == 2'b01 || steer == 2'b10)) |=> (cur == 2'b00));
    a_r5_from_d_three: assert property (@(posedge clk) disable iff (rst)
        (cur == 2'b11 && steer == 2'b11) |=> (cur == 2'b11));

    // R6
    a_r6_flag_states: assert property (@(posedge clk) disable iff (rst)
        mark == (cur == 2'b00 || cur == 2'b10));
endmodule

bind quad_steer_fsm quad_steer_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .steer (steer),
    .mark  (mark),
    .cur   (cur_q)
);

// File: tb/quad_steer_fsm_tb_top.sv
module quad_steer_fsm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] steer = 2'b00;
    logic       mark;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    quad_steer_fsm dut_i (
        .clk   (clk),
        .rst   (rst),
        .steer (steer),
        .mark  (mark)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference table, states A=0 B=1 C=2 D=3
    function automatic int ref_next(input int s, input int i);
        int t;
        t = 0;
        case (s)
            0: t = i;
            1: case (i) 0: t = 0; 1: t = 3; 2: t = 1; default: t = 3; endcase
            2: case (i) 0: t = 1; 1: t = 3; 2: t = 2; default: t = 0; endcase
            default: case (i) 0: t = 1; 1: t = 0; 2: t = 0; default: t = 3; endcase
        endcase
        return t;
    endfunction

    function automatic bit ref_flag(input int s);
        return (s == 0 || s == 2);
    endfunction

    function automatic string row_tag(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: mark actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; applies one rising edge and returns at the next falling edge
    task automatic step(input logic [1:0] v);
        steer = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2'b00);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(mark, 1'b1, "R1", "after reset");
        step(2'b00);
        check(mark, 1'b1, "R1", "home holds on 00");
    endtask

    // Visit each state/input pair, identify the landing state by its flag and its 00-successor flag
    task automatic t_all_pairs();
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                int e;
                do_reset();
                if (s != 0) step(2'(s));
                check(mark, ref_flag(s), "R6", $sformatf("flag in state %0d", s));
                step(2'(i));
                e = ref_next(s, i);
                check(mark, ref_flag(e), row_tag(s), $sformatf("state %0d steer %0d flag", s, i));
                step(2'b00);
                check(mark, ref_flag(ref_next(e, 0)), row_tag(s),
                      $sformatf("state %0d steer %0d successor flag", s, i));
            end
        end
    endtask

    // Reset and a would-be transition in the same cycle
    task automatic t_reset_priority();
        do_reset();
        step(2'b01);
        rst = 1'b1;
        step(2'b01);
        rst = 1'b0;
        check(mark, 1'b1, "R1", "reset over steer 01 from B");
        step(2'b00);
        check(mark, 1'b1, "R1", "landed in A not D");
        step(2'b10);
        rst = 1'b1;
        step(2'b00);
        rst = 1'b0;
        check(mark, 1'b1, "R1", "reset over steer 00 from C");
        step(2'b00);
        check(mark, 1'b1, "R1", "landed in A not B");
    endtask

    // Steer changes between edges must not move the flag
    task automatic t_moore();
        do_reset();
        steer = 2'b11;
        #(CLK_PERIOD/4);
        check(mark, 1'b1, "R6", "flag steady in A with steer change");
        steer = 2'b01;
        #(CLK_PERIOD/8);
        check(mark, 1'b1, "R6", "flag steady in A second change");
        @(negedge clk);
        check(mark, 1'b0, "R6", "flag low in B");
        steer = 2'b00;
        #(CLK_PERIOD/4);
        check(mark, 1'b0, "R6", "flag steady in B with steer change");
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_all_pairs();
        t_reset_priority();
        t_moore();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule